// File: doc/BRIEF.md
# Video Timing Event Interrupt Controller

This block watches an active-high video timing stream (vertical sync, data enable) together with an asynchronous tearing-effect input. It turns six timing events into latched status bits and a single combined interrupt line. The events are tearing-effect rising edge, vertical sync rising and falling edges, data-enable rising and falling edges, and end of frame. End of frame is reported on a vertical sync rising edge that follows at least one active data-enable cycle.

Software sees one 32-bit word through a plain write strobe with write data and a continuously driven read data bus. Event enables sit in the low half and write-1-to-clear status sits in the high half. A status bit is latched whether or not its event is enabled. The interrupt is raised while any latched status bit has its enable set. No streaming data passes through the block, so all pins are plain control and status signals without valid/ready handshakes.

Top module: `vtei_top`

## Requirements
- R1: After reset the read data word is 0 (all enables and all status bits clear) and the interrupt output is low.
- R2: A write loads read data bits 5:0 from write data bits 5:0 as event enables, and they keep their value until the next write; bit n enables event n, with event numbering 0 = tearing-effect rise, 1 = vertical sync rise, 2 = vertical sync fall, 3 = data-enable rise, 4 = data-enable fall, 5 = end of frame.
- R3: A rising or falling edge of vertical sync (sampled on the clock) sets status bit 17 or 18 respectively, visible on read data after the second rising clock edge following the input change.
- R4: A rising or falling edge of data enable sets status bit 19 or 20 respectively, with the same two-edge latency as R3.
- R5: The tearing-effect input passes through a two-flop synchronizer; its rising edge sets status bit 16 after the third rising clock edge following the change, not earlier, and its falling edge sets nothing.
- R6: A vertical sync rising edge sets status bit 21 (end of frame) only if data enable was sampled high in at least one cycle since the previous vertical sync rising edge, where a data-enable sample taken in the same cycle as the detected rise counts toward the frame just closed.
- R7: Status bits latch regardless of their enables, and the interrupt output equals the OR over all events of (status bit AND enable bit).
- R8: Writing 1 to a status bit (bits 21:16) clears it; writing 0 leaves it unchanged, and without a write no status bit falls.
- R9: When an event and a write-1-to-clear of its status bit happen in the same clock, the bit ends up set.
- R10: Bits 31:22 and 15:6 always read as 0 and writing them has no effect on any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, active high, synchronous to clk_i |
| de_i | input | 1 | Data enable, active high, synchronous to clk_i |
| te_i | input | 1 | Tearing-effect input, asynchronous |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, always reflecting current state |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The checker assumes that vertical sync and data enable are synchronous to the clock and hold known values from the start of reset onward, so that a change seen between two clock samples is a real edge that must appear in status two edges later. The tearing-effect input carries no such assumption and no property relates it to status timing. The bench changes every input on the falling clock edge, keeps all inputs low through reset, and drives the write strobe for exactly one cycle at a time. The enable-hold and no-spontaneous-clear properties therefore see well-defined write and no-write cycles.

// File: rtl/vtei_pkg.sv
package vtei_pkg;
  localparam int NUM_EVT    = 6;
  localparam int EV_TE      = 0;
  localparam int EV_VS_RISE = 1;
  localparam int EV_VS_FALL = 2;
  localparam int EV_DE_RISE = 3;
  localparam int EV_DE_FALL = 4;
  localparam int EV_EOF     = 5;
endpackage

// File: rtl/vtei_sync.sv
module vtei_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vtei_edge.sv
module vtei_edge #(
  parameter bit SAMPLE_IN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic lvl;
  logic prev_q;

  generate
    if (SAMPLE_IN) begin : g_sample
      logic smp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) smp_q <= 1'b0;
        else         smp_q <= sig_i;
      end
      assign lvl = smp_q;
    end else begin : g_pass
      assign lvl = sig_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign lvl_o  = lvl;
  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/vtei_eof.sv
module vtei_eof (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_rise_i,
  input  logic de_lvl_i,
  output logic eof_o
);
  logic seen_de_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_de_q <= 1'b0;
    else if (vs_rise_i) seen_de_q <= 1'b0;
    else if (de_lvl_i)  seen_de_q <= 1'b1;
  end

  assign eof_o = vs_rise_i & (seen_de_q | de_lvl_i);
endmodule

// File: rtl/vtei_regs.sv
module vtei_regs #(
  parameter int NUM_EVT  = 6,
  parameter int REG_W    = 32,
  parameter int STAT_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] st_q;
  logic [NUM_EVT-1:0] clr;

  assign clr = wr_i ? wdata_i[STAT_LSB +: NUM_EVT] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (wr_i) en_q <= wdata_i[NUM_EVT-1:0];
      st_q <= (st_q & ~clr) | evt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[NUM_EVT-1:0]        = en_q;
    rdata_o[STAT_LSB +: NUM_EVT] = st_q;
  end

  assign irq_o = |(st_q & en_q);
endmodule

// File: rtl/vtei_top.sv
module vtei_top #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 32,
  parameter int STAT_LSB    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             de_i,
  input  logic             te_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  import vtei_pkg::*;

  localparam int SYNC_SIGS = 2;
  localparam int IDX_VS    = 0;
  localparam int IDX_DE    = 1;

  logic [SYNC_SIGS-1:0] raw_in;
  logic [SYNC_SIGS-1:0] lvl, rise, fall;
  logic te_sync, te_lvl, te_rise, te_fall;
  logic eof;
  logic [NUM_EVT-1:0] evt;
  logic unused_te_bits;

  assign raw_in[IDX_VS] = vsync_i;
  assign raw_in[IDX_DE] = de_i;

  generate
    for (genvar g = 0; g < SYNC_SIGS; g++) begin : g_edge
      vtei_edge #(.SAMPLE_IN(1'b1)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (raw_in[g]),
        .lvl_o  (lvl[g]),
        .rise_o (rise[g]),
        .fall_o (fall[g])
      );
    end
  endgenerate

  vtei_sync #(.STAGES(SYNC_STAGES)) u_te_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (te_i),
    .q_o    (te_sync)
  );

  vtei_edge #(.SAMPLE_IN(1'b0)) u_te_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (te_sync),
    .lvl_o  (te_lvl),
    .rise_o (te_rise),
    .fall_o (te_fall)
  );

  assign unused_te_bits = te_lvl ^ te_fall ^ lvl[IDX_VS];

  vtei_eof u_eof (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vs_rise_i (rise[IDX_VS]),
    .de_lvl_i  (lvl[IDX_DE]),
    .eof_o     (eof)
  );

  always_comb begin
    evt             = '0;
    evt[EV_TE]      = te_rise;
    evt[EV_VS_RISE] = rise[IDX_VS];
    evt[EV_VS_FALL] = fall[IDX_VS];
    evt[EV_DE_RISE] = rise[IDX_DE];
    evt[EV_DE_FALL] = fall[IDX_DE];
    evt[EV_EOF]     = eof;
  end

  vtei_regs #(
    .NUM_EVT  (NUM_EVT),
    .REG_W    (REG_W),
    .STAT_LSB (STAT_LSB)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/vtei_checker.sv
module vtei_checker #(
  parameter int REG_W    = 32,
  parameter int STAT_LSB = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vsync_i,
  input logic             de_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o
);
  localparam int NE = vtei_pkg::NUM_EVT;

  assert_vs_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !$past(vsync_i)) |-> ##2 reg_rdata_o[STAT_LSB + vtei_pkg::EV_VS_RISE]);

  assert_de_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!de_i && $past(de_i)) |-> ##2 reg_rdata_o[STAT_LSB + vtei_pkg::EV_DE_FALL]);

  assert_en_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (reg_rdata_o[NE-1:0] == $past(reg_wdata_i[NE-1:0])));

  assert_en_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> $stable(reg_rdata_o[NE-1:0]));

  assert_no_self_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> (($past(reg_rdata_o[STAT_LSB +: NE]) & ~reg_rdata_o[STAT_LSB +: NE]) == '0));
endmodule

bind vtei_top vtei_checker #(.REG_W(REG_W), .STAT_LSB(STAT_LSB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vsync_i     (vsync_i),
  .de_i        (de_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/vtei_top_tb.sv
module vtei_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        de = 1'b0;
  logic        te = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  vtei_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vsync_i     (vsync),
    .de_i        (de),
    .te_i        (te),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [31:0] d);
    wr = 1'b1;
    wdata = d;
    cyc(1);
    wr = 1'b0;
    wdata = '0;
  endtask

  function automatic logic [31:0] stat();
    return {26'd0, rdata[21:16]};
  endfunction

  task automatic t_reset();
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_enable_rw();
    wr_reg(32'h0000_0015);
    chk("R2 enable readback 15", rdata, 32'h0000_0015);
    cyc(3);
    chk("R2 enable held", rdata, 32'h0000_0015);
    wr_reg(32'h0000_002A);
    chk("R2 enable readback 2A", rdata, 32'h0000_002A);
    wr_reg(32'h0);
  endtask

  task automatic t_vsync();
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(1);
    chk("R3 vsync rise not yet", stat(), 32'h00);
    cyc(1);
    chk("R3 vsync rise", stat(), 32'h02);
    vsync = 1'b0;
    cyc(2);
    chk("R3 vsync fall", stat(), 32'h06);
  endtask

  task automatic t_de();
    wr_reg(32'h003F_0000);
    de = 1'b1;
    cyc(2);
    chk("R4 de rise", stat(), 32'h08);
    de = 1'b0;
    cyc(2);
    chk("R4 de fall", stat(), 32'h18);
  endtask

  task automatic t_te();
    wr_reg(32'h003F_0000);
    te = 1'b1;
    cyc(2);
    chk("R5 te not before third edge", stat(), 32'h00);
    cyc(1);
    chk("R5 te rise", stat(), 32'h01);
    wr_reg(32'h003F_0000);
    te = 1'b0;
    cyc(4);
    chk("R5 te fall ignored", stat(), 32'h00);
  endtask

  task automatic t_eof();
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(2);
    chk("R6 eof after frame with de", stat(), 32'h22);
    vsync = 1'b0;
    cyc(2);
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(2);
    chk("R6 no eof without de", stat(), 32'h02);
    vsync = 1'b0;
    cyc(2);
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    de = 1'b1;
    cyc(2);
    chk("R6 eof with de in same cycle", stat(), 32'h2A);
    de = 1'b0;
    vsync = 1'b0;
    cyc(2);
  endtask

  task automatic t_irq();
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(2);
    chk("R7 status latched while disabled", {31'd0, rdata[17]}, 32'h1);
    chk("R7 irq low when disabled", {31'd0, irq}, 32'h0);
    wr_reg(32'h0000_0002);
    chk("R7 irq high when enabled", {31'd0, irq}, 32'h1);
    wr_reg(32'h0000_0004);
    chk("R7 irq low other enable", {31'd0, irq}, 32'h0);
    vsync = 1'b0;
    cyc(2);
    chk("R7 irq from vsync fall", {31'd0, irq}, 32'h1);
    wr_reg(32'h0);
    chk("R7 irq low all disabled", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(2);
    vsync = 1'b0;
    cyc(2);
    chk("R8 setup status", stat(), 32'h06);
    wr_reg(32'h0004_0000);
    chk("R8 write one clears", stat(), 32'h02);
    wr_reg(32'h0000_0000);
    chk("R8 write zero keeps", stat(), 32'h02);
  endtask

  task automatic t_set_wins();
    wr_reg(32'h003F_0000);
    vsync = 1'b1;
    cyc(1);
    wr_reg(32'h0002_0000);
    chk("R9 set wins over clear", stat(), 32'h02);
    vsync = 1'b0;
    cyc(2);
  endtask

  task automatic t_reserved();
    wr_reg(32'hFFC0_FFFF);
    chk("R10 reserved read zero", rdata, 32'h0006_003F);
    wr_reg(32'h003F_0000);
    chk("R10 final clear", rdata, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_enable_rw();
    t_vsync();
    t_de();
    t_te();
    t_eof();
    t_irq();
    t_w1c();
    t_set_wins();
    t_reserved();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule